// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block derives a serial bit-rate enable from a fast base clock. The base clock first goes through an 8-bit time-constant divider, which counts enabled cycles and reaches a terminal count once every `TC` cycles. Those terminal counts then feed a power-of-two prescaler whose exponent comes from a 4-bit field. The result is a single-cycle `tick` strobe once every `TC * 2^E` base cycles. A registered square wave `baud_clk` is also produced, with equal high and low times whenever the exponent is at least one.

A shifter that needs one enable per bit time uses the block by programming a time constant and an exponent, then raising `en`. New divider settings do not disturb the period in progress; they are taken up at the next terminal count of the time-constant divider. Lowering `en` puts the generator back to its starting point.

Top module: `baud_gen`

## Requirements
- R1: After reset both `tick` and `baud_clk` are low, and they stay low while `en` is low.
- R2: With `en` held high, `tick` is high for one cycle in every `TCe * 2^E` base cycles. TCe is the time-constant input, except that a value of 0 counts as 256. E is the exponent input.
- R3: A time-constant input of 0 divides by 256. With an exponent of 0, ticks are 256 cycles apart.
- R4: An exponent input greater than 9 is treated as 9. For example, 12 with a time constant of 2 gives a period of 1024 cycles.
- R5: A time constant of 1 with an exponent of 0 raises `tick` on every base cycle while `en` is high.
- R6: The slowest setting, time constant 0 with exponent 9, gives its first tick 131072 cycles after enabling.
- R7: After `en` rises, `tick` is first seen high after the N-th rising edge at which `en` is high, where N = TCe * 2^E.
- R8: A change to the time-constant or exponent input takes effect at the next terminal count of the time-constant divider. Until then the old values govern.
- R9: Lowering `en` clears both counters at the next edge. `tick` and `baud_clk` are low after that edge, and the next enable restarts timing as in R7.
- R10: With E ≥ 1, `baud_clk` is high for exactly N/2 cycles of every N-cycle period. It rises at the midpoint of the prescaler count and falls together with the wrap that raises `tick`. With E = 0, `baud_clk` equals `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low clears the counters |
| tc_val | input | 8 | Time constant; 0 means 256 |
| exp_val | input | 4 | Prescaler exponent; values above 9 are treated as 9 |
| tick | output | 1 | One-cycle strobe at the bit rate |
| baud_clk | output | 1 | Registered square wave at the bit rate |

## Verification
Both outputs are registered, so the effect of an input seen at a rising edge appears right after that edge. The bench drives inputs and samples outputs on the falling edge, which places each result half a cycle after the edge that produced it. The first tick after enabling is due at the N-th falling edge after `en` is raised: the bench counts those edges and compares the count with N. A behavioural model steps with every rising edge and is compared with both outputs at each falling edge, which covers reloads that happen in the middle of a period and clears caused by the enable.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Saturate a requested exponent to the largest supported value.
  function automatic int clamp_exp(input int req, input int max_e);
    return (req > max_e) ? max_e : req;
  endfunction
endpackage

// File: rtl/brg_tc_stage.sv
module brg_tc_stage #(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter int EXPA_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TC_W-1:0]   tc_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic              tc_done,
  output logic [TC_W-1:0]   cnt,
  output logic [TC_W-1:0]   tc_last,
  output logic [EXPA_W-1:0] exp_act
);
  import baud_gen_pkg::*;

  logic [TC_W-1:0]   cnt_d, tc_last_d, limit;
  logic [EXPA_W-1:0] exp_act_d, exp_clamped;
  logic              load;

  // Terminal value is tc-1 in TC_W bits, so 0 wraps to the full range.
  assign limit       = tc_last - TC_W'(1);
  assign exp_clamped = EXPA_W'(clamp_exp(int'(exp_in), MAX_EXP));
  assign tc_done     = en && (cnt == limit);
  assign load        = !en || tc_done;

  always_comb begin
    cnt_d     = cnt;
    tc_last_d = tc_last;
    exp_act_d = exp_act;
    if (!en)          cnt_d = '0;
    else if (tc_done) cnt_d = '0;
    else              cnt_d = cnt + TC_W'(1);
    if (load) begin
      tc_last_d = tc_in;
      exp_act_d = exp_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tc_last <= '0;
      exp_act <= '0;
    end else begin
      cnt     <= cnt_d;
      tc_last <= tc_last_d;
      exp_act <= exp_act_d;
    end
  end
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int PRE_W  = 9,
  parameter int EXPA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tc_done,
  input  logic [EXPA_W-1:0] exp_act,
  output logic [PRE_W-1:0]  pre,
  output logic [PRE_W-1:0]  pre_nxt,
  output logic              tick_nxt,
  output logic              tick
);
  logic low_full;

  // All prescaler bits below the active exponent are ones.
  always_comb begin
    low_full = 1'b1;
    for (int i = 0; i < PRE_W; i++) begin
      if ((EXPA_W'(i) < exp_act) && !pre[i]) low_full = 1'b0;
    end
  end

  always_comb begin
    pre_nxt  = pre;
    tick_nxt = 1'b0;
    if (!en) begin
      pre_nxt = '0;
    end else if (tc_done) begin
      pre_nxt  = pre + PRE_W'(1);
      tick_nxt = low_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tick <= 1'b0;
    end else begin
      pre  <= pre_nxt;
      tick <= tick_nxt;
    end
  end
endmodule

// File: rtl/brg_clk_out.sv
module brg_clk_out #(
  parameter bit GEN_CLK = 1'b1,
  parameter int PRE_W   = 9,
  parameter int EXPA_W  = 4,
  parameter int MAX_EXP = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  pre_nxt,
  input  logic [EXPA_W-1:0] exp_act,
  input  logic              tick_nxt,
  output logic              baud_clk
);
  generate
    if (GEN_CLK) begin : g_sq
      logic sel;
      logic clk_q;
      always_comb begin
        sel = tick_nxt;
        for (int i = 1; i <= MAX_EXP; i++) begin
          if (exp_act == EXPA_W'(i)) sel = pre_nxt[i-1];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= sel;
      end
      assign baud_clk = clk_q;
    end else begin : g_none
      assign baud_clk = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter bit GEN_CLK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TC_W-1:0]  tc_val,
  input  logic [EXP_W-1:0] exp_val,
  output logic             tick,
  output logic             baud_clk
);
  localparam int PRE_W  = MAX_EXP;
  localparam int EXPA_W = $clog2(MAX_EXP + 1);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              tc_done;
  logic [TC_W-1:0]   cnt;
  logic [TC_W-1:0]   tc_last;
  logic [EXPA_W-1:0] exp_act;
  logic [PRE_W-1:0]  pre;
  logic [PRE_W-1:0]  pre_nxt;
  logic              tick_nxt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  brg_tc_stage #(
    .TC_W(TC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .EXPA_W(EXPA_W)
  ) u_tc (
    .clk(clk), .rst_n(rst_int_n), .en(en), .tc_in(tc_val), .exp_in(exp_val),
    .tc_done(tc_done), .cnt(cnt), .tc_last(tc_last), .exp_act(exp_act)
  );

  brg_prescale #(.PRE_W(PRE_W), .EXPA_W(EXPA_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .en(en), .tc_done(tc_done),
    .exp_act(exp_act), .pre(pre), .pre_nxt(pre_nxt),
    .tick_nxt(tick_nxt), .tick(tick)
  );

  brg_clk_out #(
    .GEN_CLK(GEN_CLK), .PRE_W(PRE_W), .EXPA_W(EXPA_W), .MAX_EXP(MAX_EXP)
  ) u_clk (
    .clk(clk), .rst_n(rst_int_n), .pre_nxt(pre_nxt), .exp_act(exp_act),
    .tick_nxt(tick_nxt), .baud_clk(baud_clk)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int TC_W    = 8,
  parameter int PRE_W   = 9,
  parameter int EXPA_W  = 4,
  parameter int MAX_EXP = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic              baud_clk,
  input logic              tc_done,
  input logic [TC_W-1:0]   cnt,
  input logic [TC_W-1:0]   tc_last,
  input logic [EXPA_W-1:0] exp_act,
  input logic [PRE_W-1:0]  pre
);
  // R9: a low enable leaves both outputs low after the next edge
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick && !baud_clk));

  // R2: a tick rises only after a terminal count of the time-constant divider
  a_r2_tick_from_tc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick) |-> $past(tc_done));

  // R2: ticks are single-cycle unless the divider runs at the base rate
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tc_last != TC_W'(1)) |=> !tick);

  // R8: prescaler holds between terminal counts
  a_r8_pre_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tc_done) |=> $stable(pre));

  // R3: counter never passes the active terminal value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (tc_last - TC_W'(1)));

  // R4: active exponent saturated
  a_r4_exp_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    exp_act <= EXPA_W'(MAX_EXP));
endmodule

bind baud_gen baud_gen_chk #(
  .TC_W(TC_W), .PRE_W(PRE_W), .EXPA_W(EXPA_W), .MAX_EXP(MAX_EXP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .baud_clk(baud_clk),
  .tc_done(tc_done), .cnt(cnt), .tc_last(tc_last), .exp_act(exp_act),
  .pre(pre)
);

// File: tb/baud_gen_test.sv
module baud_gen_test;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic [7:0] tc_val;
  logic [3:0] exp_val;
  logic       tick;
  logic       baud_clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  bit    cmp_on   = 0;
  string cur_req  = "R1";

  // behavioural reference state
  int m_tce, m_e, m_cnt, m_pre;
  bit m_tick, m_clk;

  baud_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .tc_val(tc_val), .exp_val(exp_val),
    .tick(tick), .baud_clk(baud_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int eff_tc(input int v);
    return (v == 0) ? 256 : v;
  endfunction
  function automatic int eff_e(input int v);
    return (v > 9) ? 9 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tce = 256; m_e = 0; m_cnt = 0; m_pre = 0; m_tick = 0; m_clk = 0;
    end else if (!en) begin
      m_cnt = 0; m_pre = 0; m_tick = 0; m_clk = 0;
      m_tce = eff_tc(tc_val); m_e = eff_e(exp_val);
    end else begin
      bit hit;
      hit = (m_cnt == m_tce - 1);
      m_tick = hit && ((m_pre % (2 ** m_e)) == (2 ** m_e) - 1);
      if (hit) m_pre = (m_pre + 1) % 512;
      m_clk = (m_e == 0) ? m_tick : bit'((m_pre >> (m_e - 1)) & 1);
      if (hit) begin
        m_cnt = 0;
        m_tce = eff_tc(tc_val);
        m_e   = eff_e(exp_val);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_checks++;
      if (tick !== m_tick || baud_clk !== m_clk) begin
        n_fail++;
        $display("FAIL %s model: tick=%b clk=%b expected tick=%b clk=%b",
                 cur_req, tick, baud_clk, m_tick, m_clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // restart with new settings and count falling edges until the first tick
  task automatic first_tick(input string req, input int tcv, input int ev,
                            input int expn);
    int k;
    @(negedge clk);
    en = 1'b0; tc_val = 8'(tcv); exp_val = 4'(ev);
    @(negedge clk);
    en = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k <= expn + 2);
    check(req, k, expn);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; tc_val = 8'd1; exp_val = 4'd0;
    run(3);
    rst_n = 1'b1;
    run(6);
    cmp_on = 1;
    cur_req = "R1";
    check("R1 tick", int'(tick), 0);
    check("R1 baud_clk", int'(baud_clk), 0);
    run(4);

    cur_req = "R5";
    first_tick("R5 first", 1, 0, 1);
    begin
      int hi = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); hi += int'(tick); end
      check("R5 every cycle", hi, 10);
    end

    cur_req = "R9";
    en = 1'b0;
    @(negedge clk);
    check("R9 tick cleared", int'(tick), 0);
    check("R9 clk cleared", int'(baud_clk), 0);

    cur_req = "R7";
    first_tick("R7 3x4", 3, 2, 12);
    cur_req = "R2";
    run(100);

    cur_req = "R10";
    first_tick("R10 5x2", 5, 1, 10);
    begin
      int hi = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); hi += int'(baud_clk); end
      check("R10 duty", hi, 5);
    end
    run(60);

    cur_req = "R3";
    first_tick("R3 256", 0, 0, 256);
    run(300);

    cur_req = "R4";
    first_tick("R4 clamp", 2, 12, 1024);
    run(1100);

    cur_req = "R8";
    first_tick("R8 base", 4, 1, 8);
    run(3);
    tc_val = 8'd7; exp_val = 4'd2;
    run(150);
    tc_val = 8'd3; exp_val = 4'd0;
    run(40);

    cur_req = "R9";
    en = 1'b0;
    run(2);
    check("R9 idle tick", int'(tick), 0);
    first_tick("R9 restart", 6, 1, 12);

    cur_req = "R6";
    first_tick("R6 slowest", 0, 9, 131072);
    run(5);

    finish_run();
  end
endmodule